// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a programmed run of data items from a source region to a destination region over a simple request/grant memory port. Software loads two 32-bit start addresses, an item-count register, an interrupt-match value and a control word. It then sets the enable bit. Each item is a read of the source followed by a write of the fetched value to the destination. The engine keeps an item index that it uses to form both addresses.

A transfer can start as soon as the channel is enabled, or each item can wait for a peripheral request. That request is taken either as a level or as a rising edge. Other options are a circular restart for request-driven streams, a fill mode that writes one fetched value to a whole destination range, and an idle-insert mode that leaves the bus free for one cycle after every store. An interrupt pulse can mark the completion of a chosen item.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, chan_on is 0, item_idx is 0, and bus_req and irq_pulse are both low.
- R2: A length value of N gives exactly N+1 destination writes. In normal mode, chan_on drops in the cycle after the last write is granted, and item_idx reads 0 from that cycle on.
- R3: Control bits [2:1] choose the item size, with 0 for one byte, 1 for two bytes and 2 for four bytes. bus_size carries this code. Code 3 never starts a transfer, and no bus request is made while it is set.
- R4: Item k is read from source start + k·size and written to destination start + k·size. The write carries the data read for that item. If source increment (bit 6) or destination increment (bit 5) is clear, that side stays at its start address.
- R5: When interrupt enable (bit 3) is set, irq_pulse is high for one cycle, in the cycle after the write of the item whose index (before it advances) equals the match value. When bit 3 is clear, no pulse is produced.
- R6: When circular (bit 7) and trigger mode (bit 4) are both set, completing the last item leaves chan_on at 1, returns item_idx to 0, and the next item goes back to the start addresses. When bit 4 is clear, circular has no effect.
- R7: When trigger mode is on with level sense (bit 10 clear), an item starts only from a cycle in which periph_req is high.
- R8: When trigger mode is on with edge sense (bit 10 set), each rising edge of periph_req allows exactly one item. A request held high allows only one item.
- R9: In fill mode (bit 9), the source is read once and that value is written to every destination item.
- R10: Without trigger mode, each non-final store is followed by one cycle with bus_req low when idle insert (bit 8) is set. When bit 8 is clear, the next access follows the store with no gap.
- R11: When software clears the enable bit (bit 0) mid-transfer, the item in flight finishes and no further item starts. item_idx returns to 0.
- R12: A bus request that is not granted stays asserted, with its address and direction unchanged, until bus_gnt is high.
- R13: The configuration is written through cfg_addr: 0 for source start, 1 for destination start, 2 for length (16 bits), 3 for match value (16 bits), and 4 for control. A software write takes priority over the hardware self-clear of the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| periph_req | input | 1 | Peripheral transfer request |
| bus_req | output | 1 | Memory access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_size | output | 2 | Item size code |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_gnt | input | 1 | Access granted and completed this cycle |
| bus_rdata | input | 32 | Read data, valid in the granted cycle |
| chan_on | output | 1 | Enable bit as currently held |
| item_idx | output | 16 | Items completed in the current pass |
| irq_pulse | output | 1 | One-cycle index-match interrupt |

## Verification
Two pairs of events are made to land in the same cycle.

The first pair is the index-match interrupt and the completion of the transfer. The bench sets the match value equal to the length, so the interrupt is judged on the index from before the reset, in the same cycle that the index returns to 0 and the enable bit clears. The bench checks that exactly one pulse appears one cycle after the final write, and that item_idx and chan_on both read 0.

The second pair is a software abort and an item in flight. The bench holds grant low so a read stays pending, clears the enable bit, and then releases grant. The bench checks that exactly one write completes and that the index returns to 0.

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 16,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          periph_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          chan_on,
  output logic [IW-1:0] item_idx,
  output logic          irq_pulse
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RD = 2'd1, S_WR = 2'd2, S_WAIT = 2'd3} st_t;

  st_t           state;
  logic [AW-1:0] src_q, dst_q;
  logic [IW-1:0] len_q, match_q, idx_q;
  logic [CW-1:0] ctrl_q;
  logic [DW-1:0] data_q;
  logic          fill_have, pend_q, req_q, irq_q;

  logic       on, irq_en, trig, dst_inc, src_inc, circ, idle_m, fill, edge_s;
  logic [1:0] width;
  assign on      = ctrl_q[0];
  assign width   = ctrl_q[2:1];
  assign irq_en  = ctrl_q[3];
  assign trig    = ctrl_q[4];
  assign dst_inc = ctrl_q[5];
  assign src_inc = ctrl_q[6];
  assign circ    = ctrl_q[7];
  assign idle_m  = ctrl_q[8];
  assign fill    = ctrl_q[9];
  assign edge_s  = ctrl_q[10];

  logic          wr_done, at_end, rearm, req_ok, go;
  logic [AW-1:0] step, off_src, off_dst;
  st_t           first_op;

  assign wr_done  = (state == S_WR) && bus_gnt;
  assign at_end   = (idx_q == len_q);
  assign rearm    = circ && trig;
  assign req_ok   = edge_s ? pend_q : periph_req;
  assign go       = on && (width != 2'b11) && (!trig || req_ok);
  assign first_op = (fill && fill_have) ? S_WR : S_RD;
  assign step     = {{(AW-IW){1'b0}}, idx_q} << width;
  assign off_src  = (src_inc && !fill) ? step : '0;
  assign off_dst  = dst_inc ? step : '0;

  assign bus_req   = (state == S_RD) || (state == S_WR);
  assign bus_we    = (state == S_WR);
  assign bus_size  = width;
  assign bus_addr  = (state == S_WR) ? dst_q + off_dst : src_q + off_src;
  assign bus_wdata = data_q;
  assign chan_on   = on;
  assign item_idx  = idx_q;
  assign irq_pulse = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0:    src_q   <= cfg_wdata;
        3'd1:    dst_q   <= cfg_wdata;
        3'd2:    len_q   <= cfg_wdata[IW-1:0];
        3'd3:    match_q <= cfg_wdata[IW-1:0];
        3'd4:    ctrl_q  <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end else if (wr_done && at_end && !rearm) begin
      ctrl_q[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      req_q  <= periph_req;
      pend_q <= on && edge_s && ((pend_q && !wr_done) || (periph_req && !req_q));
      irq_q  <= wr_done && irq_en && (match_q == idx_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx_q     <= '0;
      data_q    <= '0;
      fill_have <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (!on) begin
            idx_q     <= '0;
            fill_have <= 1'b0;
          end else if (go) begin
            state <= first_op;
          end
        end
        S_RD: begin
          if (bus_gnt) begin
            data_q    <= bus_rdata;
            fill_have <= 1'b1;
            state     <= S_WR;
          end
        end
        S_WR: begin
          if (bus_gnt) begin
            if (at_end || !on) begin
              idx_q     <= '0;
              fill_have <= 1'b0;
              state     <= S_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              if (trig)        state <= S_IDLE;
              else if (idle_m) state <= S_WAIT;
              else             state <= first_op;
            end
          end
        end
        S_WAIT: begin
          if (!on) begin
            idx_q     <= '0;
            fill_have <= 1'b0;
            state     <= S_IDLE;
          end else begin
            state <= first_op;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        periph_req,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_gnt,
  input logic [31:0] bus_addr,
  input logic        irq_pulse,
  input logic        chan_on,
  input logic [1:0]  st,
  input logic [1:0]  width,
  input logic        trig,
  input logic        edge_s,
  input logic        idle_m,
  input logic        at_end
);
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !cfg_we) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  assert_irq_after_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(bus_req && bus_we && bus_gnt));

  assert_no_reserved_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && width == 2'b11) |=> !bus_req);

  assert_level_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && trig && !edge_s && !periph_req) |=> !bus_req);

  assert_idle_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_gnt && !at_end && idle_m && !trig) |=> !bus_req);

  assert_self_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_gnt && at_end && !trig && !cfg_we) |=> !chan_on);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .periph_req(periph_req),
  .bus_req(bus_req), .bus_we(bus_we), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
  .irq_pulse(irq_pulse), .chan_on(chan_on), .st(state), .width(width),
  .trig(trig), .edge_s(edge_s), .idle_m(idle_m), .at_end(at_end)
);

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        periph_req = 1'b0;
  logic        bus_req, bus_we, bus_gnt;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        chan_on, irq_pulse;
  logic [15:0] item_idx;

  localparam logic [31:0] PAT = 32'hC3C3_0000;
  assign bus_rdata = bus_addr ^ PAT;

  always #2 clk = ~clk;

  dma_xfer_engine u_dma_xfer_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .periph_req(periph_req), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .chan_on(chan_on), .item_idx(item_idx), .irq_pulse(irq_pulse)
  );

  int unsigned n_chk = 0, n_fail = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] wr_addr [0:511];
  logic [31:0] wr_data [0:511];
  logic [1:0]  wr_size [0:511];
  int unsigned wr_cyc  [0:511];
  int unsigned wr_n = 0, rd_n = 0, irq_n = 0, irq_cyc = 0;

  always @(negedge clk) begin
    if (rst_n && bus_req && bus_gnt) begin
      if (bus_we) begin
        if (wr_n < 512) begin
          wr_addr[wr_n] <= bus_addr;
          wr_data[wr_n] <= bus_wdata;
          wr_size[wr_n] <= bus_size;
          wr_cyc[wr_n]  <= cyc;
        end
        wr_n <= wr_n + 1;
      end else begin
        rd_n <= rd_n + 1;
      end
    end
    if (rst_n && irq_pulse) begin
      irq_n   <= irq_n + 1;
      irq_cyc <= cyc;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R13 register map: 0 src, 1 dst, 2 len, 3 match, 4 control
  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic on, input logic [1:0] w, input logic ie,
      input logic tr, input logic di, input logic si, input logic ci, input logic id,
      input logic fl, input logic ed);
    return {21'd0, ed, fl, id, ci, si, di, tr, ie, w, on};
  endfunction

  task automatic wait_off();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!chan_on) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req_set(input logic v);
    @(posedge clk); #1;
    periph_req = v;
  endtask

  typedef struct packed {
    logic [1:0]  w;
    logic        si;
    logic        di;
    logic        idle;
    logic        fill;
    logic [15:0] len;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] last_dst;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd3, 32'h0000_1000, 32'h0000_2000, 32'h0000_2003},
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd2, 32'h0000_1100, 32'h0000_2100, 32'h0000_2104},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'd4, 32'h0000_1200, 32'h0000_2200, 32'h0000_2210},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1, 32'h0000_1300, 32'h0000_2300, 32'h0000_2300},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 16'd5, 32'h0000_1400, 32'h0000_2400, 32'h0000_2405},
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd2, 32'h0000_1500, 32'h0000_2500, 32'h0000_2504}
  };

  bit done = 0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned w0, r0;
    bus_gnt = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 chan_on", chan_on, 0);
    check("R1 item_idx", item_idx, 0);
    check("R1 bus_req", bus_req, 0);
    check("R1 irq_pulse", irq_pulse, 0);

    for (int v = 0; v < 6; v++) begin
      w0 = wr_n; r0 = rd_n;
      cfg(0, VEC[v].src); cfg(1, VEC[v].dst); cfg(2, {16'd0, VEC[v].len});
      cfg(4, mk(1, VEC[v].w, 0, 0, VEC[v].di, VEC[v].si, 0, VEC[v].idle, VEC[v].fill, 0));
      wait_off();
      check("R2 write count", wr_n - w0, VEC[v].len + 1);
      check("R9 read count", rd_n - r0, VEC[v].fill ? 1 : VEC[v].len + 1);
      check("R2 idx back to 0", item_idx, 0);
      check("R2 chan_on cleared", chan_on, 0);
      check("R4 last dst", wr_addr[w0 + VEC[v].len], VEC[v].last_dst);
      for (int k = 0; k <= int'(VEC[v].len); k++) begin
        logic [31:0] ed, es;
        ed = VEC[v].dst + (VEC[v].di ? (32'(k) << VEC[v].w) : 32'd0);
        es = VEC[v].fill ? VEC[v].src : VEC[v].src + (VEC[v].si ? (32'(k) << VEC[v].w) : 32'd0);
        check("R4 dst addr", wr_addr[w0 + k], ed);
        check("R4 R9 write data", wr_data[w0 + k], es ^ PAT);
        check("R3 size code", {30'd0, wr_size[w0 + k]}, {30'd0, VEC[v].w});
        if (k > 0)
          check("R10 store spacing", wr_cyc[w0 + k] - wr_cyc[w0 + k - 1],
                (VEC[v].fill ? 1 : 2) + (VEC[v].idle ? 1 : 0));
      end
    end

    // R3 reserved size code
    w0 = wr_n;
    cfg(2, 2); cfg(4, mk(1, 2'b11, 0, 0, 1, 1, 0, 0, 0, 0));
    cycles(10);
    check("R3 reserved no write", wr_n - w0, 0);
    check("R3 reserved no req", bus_req, 0);
    cfg(4, 0);

    // R5 interrupt coinciding with final item
    w0 = wr_n; r0 = irq_n;
    cfg(0, 32'h3000); cfg(1, 32'h4000); cfg(2, 3); cfg(3, 3);
    cfg(4, mk(1, 2'd2, 1, 0, 1, 1, 0, 0, 0, 0));
    wait_off();
    check("R5 one pulse", irq_n - r0, 1);
    check("R5 pulse timing", irq_cyc - wr_cyc[w0 + 3], 1);
    check("R2 idx after irq end", item_idx, 0);
    r0 = irq_n;
    cfg(4, mk(1, 2'd2, 0, 0, 1, 1, 0, 0, 0, 0));
    wait_off();
    check("R5 disabled no pulse", irq_n - r0, 0);

    // R7 level trigger
    w0 = wr_n;
    cfg(2, 2); cfg(4, mk(1, 2'd0, 0, 1, 1, 1, 0, 0, 0, 0));
    cycles(10);
    check("R7 waits for req", wr_n - w0, 0);
    req_set(1); req_set(0);
    cycles(8);
    check("R7 one item per high cycle", wr_n - w0, 1);
    check("R7 idx", item_idx, 1);
    req_set(1);
    wait_off();
    req_set(0);
    check("R7 finishes", wr_n - w0, 3);

    // R8 edge trigger
    w0 = wr_n;
    cfg(4, mk(1, 2'd0, 0, 1, 1, 1, 0, 0, 0, 1));
    req_set(1);
    cycles(12);
    check("R8 held high one item", wr_n - w0, 1);
    req_set(0); req_set(1);
    cycles(8);
    check("R8 second edge", wr_n - w0, 2);
    req_set(0);
    cfg(4, 0);

    // R6 circular with edge trigger
    w0 = wr_n;
    cfg(1, 32'h5000); cfg(2, 1);
    cfg(4, mk(1, 2'd0, 0, 1, 1, 1, 1, 0, 0, 1));
    req_set(1); req_set(0); cycles(6);
    req_set(1); req_set(0); cycles(6);
    check("R6 pass done", wr_n - w0, 2);
    check("R6 stays on", chan_on, 1);
    check("R6 idx reset", item_idx, 0);
    req_set(1); req_set(0); cycles(6);
    check("R6 restart addr", wr_addr[w0 + 2], 32'h5000);
    cfg(4, 0);
    cycles(3);
    w0 = wr_n;
    cfg(4, mk(1, 2'd0, 0, 0, 1, 1, 1, 0, 0, 0));
    wait_off();
    check("R6 no effect untriggered", chan_on, 0);
    check("R6 untriggered count", wr_n - w0, 2);

    // R11 abort while a read waits; R12 hold
    w0 = wr_n;
    @(posedge clk); #1 bus_gnt = 1'b0;
    cfg(0, 32'h6000); cfg(2, 20);
    cfg(4, mk(1, 2'd2, 0, 0, 1, 1, 0, 0, 0, 0));
    cycles(3);
    check("R12 req held", bus_req, 1);
    check("R12 addr held", bus_addr, 32'h6000);
    cfg(4, 0);
    @(posedge clk); #1 bus_gnt = 1'b1;
    cycles(10);
    check("R11 one item finishes", wr_n - w0, 1);
    check("R11 idx reset", item_idx, 0);
    check("R11 no further req", bus_req, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule